// File: doc/BRIEF.md
# Fluorescent Display Digit Timing Generator

This block produces the repeating on/off timing for one digit slot of a vacuum fluorescent display driver. A free-running prescaler turns the input clock into a slow tick. A period counter runs on that tick and repeats every `n+1` ticks, where `n` is the programmed period value. Every display port enable is held low for a short blanking interval at the start of each slot. This stops ghosting between digits and sets the overall brightness.

After the blank, each port turns on. A bright port stays on until the slot ends. A dark port is cut off early, at a programmed count, which gives a two-level grayscale. The early cut-off applies only when the global grayscale switch is on and that port's gradation bit is set.

Software reaches the block through a simple synchronous write port and a combinational read port. Timing values written during a slot are held in shadow copies and take effect at the next slot boundary. A single-cycle strobe marks the last cycle of every slot.

Top module: `vfd_timing_gen`

## Requirements
- R1: The slot lasts (P+1) ticks, where P is the period value written at address 1. The strobe `slot_end` is high for exactly one clock, in the last clock of each slot. The slot counter runs 0..P.
- R2: With mode bit 1 (source select) = 0, one tick is DIV0 input clocks (default 32). The counter advances only on ticks.
- R3: With mode bit 1 = 1, one tick is DIV1 input clocks (default 128).
- R4: While the slot count is below the blank value B (address 2), every port enable is low. With B = 0, ports may be on from count 0.
- R5: From count B until the slot ends, a bright port enable is high.
- R6: When mode bit 2 (grayscale) = 1 and a port's gradation bit (address 4, bit i for port i) = 1, that port is low for every count at or above the cut-off value C (address 3), until the slot ends.
- R7: When mode bit 2 = 0, the gradation bits have no effect and every port follows the bright behaviour.
- R8: A read of address 1 returns the live slot count. Reads of addresses 0, 2, 3 and 4 return the value last written there.
- R9: Writes to the period, blank, cut-off, gradation and grayscale settings do not change the slot in progress. They apply from the next slot.
- R10: While mode bit 0 (enable) = 0, all port enables and the strobe are low and the count is held at 0. Setting the bit starts a slot from count 0.
- R11: After reset, all registers read 0, all port enables are low and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 mode, 1 period, 2 blank, 3 cut-off, 4 gradation) |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DW | Read data (address 1 gives the live count) |
| port_en | output | NPORT | Per-port display enables |
| slot_end | output | 1 | One-cycle pulse in the last clock of each slot |

## Verification
The bench builds the block with DIV0 = 4, DIV1 = 8, NPORT = 4 and DW = 8. These short ticks let whole slots, and several slots in a row, be checked clock by clock against a count that the bench derives from elapsed cycles. They also bring both source-select settings and the slot-boundary shadow load into a short run. A narrow port vector is enough to mix dark and bright ports in the same slot.

// File: rtl/vfd_pkg.sv
// Shared register addresses and mode-bit positions for the digit timing generator.
// Assumes a 3-bit register address space.
package vfd_pkg;
    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_PER   = 3'd1;
    localparam logic [2:0] A_BLANK = 3'd2;
    localparam logic [2:0] A_CUT   = 3'd3;
    localparam logic [2:0] A_GRAD  = 3'd4;
    localparam int M_EN   = 0;
    localparam int M_SEL  = 1;
    localparam int M_GRAY = 2;
endpackage

// File: rtl/vfd_prescaler.sv
// Free-running divider that emits a one-clock tick every DIV0 or DIV1 clocks.
// Assumes DIV0, DIV1 >= 2. It is held at zero while run is low.
module vfd_prescaler #(
    parameter int DIV0 = 32,
    parameter int DIV1 = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic tick
);
    localparam int DMAX = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int PW   = $clog2(DMAX);
    localparam logic [PW-1:0] LIM0 = PW'(DIV0 - 1);
    localparam logic [PW-1:0] LIM1 = PW'(DIV1 - 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    // Pick the terminal value from the source select.
    always_comb lim = sel ? LIM1 : LIM0;

    assign tick = run && (pcnt >= lim);

    // Advance the divider, wrapping on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/vfd_slot_counter.sv
// Slot counter: counts ticks 0..per and flags the last clock of the slot.
// Assumes per is stable within a slot (the caller supplies the shadow copy).
module vfd_slot_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [DW-1:0] per,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    assign wrap = tick && (cnt == per);

    // Count ticks, return to zero at the slot end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/vfd_port_gate.sv
// One port enable: off during the blank, then on until the slot end (bright)
// or until the cut-off count (dark). Assumes blank < cut <= per.
module vfd_port_gate #(
    parameter int DW = 8
) (
    input  logic          run,
    input  logic          dark,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] blank,
    input  logic [DW-1:0] cut,
    output logic          en
);
    // Combine the leading blank and the optional trailing cut-off.
    always_comb en = run && (cnt >= blank) && !(dark && (cnt >= cut));
endmodule

// File: rtl/vfd_timing_gen.sv
// Top of the digit timing generator: register file, shadow copies loaded at
// slot boundaries, prescaler, slot counter and one gate per port.
// Assumes NPORT <= DW and that software keeps blank < cut < per+1.
module vfd_timing_gen
    import vfd_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int DW    = 8,
    parameter int DIV0  = 32,
    parameter int DIV1  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [NPORT-1:0] port_en,
    output logic             slot_end
);
    logic [2:0]       mode_r;
    logic [DW-1:0]    per_r, blank_r, cut_r;
    logic [NPORT-1:0] grad_r;
    logic [DW-1:0]    per_sh, blank_sh, cut_sh;
    logic [NPORT-1:0] grad_sh;
    logic             gray_sh;
    logic             run, tick, wrap;
    logic [DW-1:0]    cnt;

    assign run = mode_r[M_EN];

    // Software register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r  <= '0;
            per_r   <= '0;
            blank_r <= '0;
            cut_r   <= '0;
            grad_r  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:  mode_r  <= wr_data[2:0];
                A_PER:   per_r   <= wr_data;
                A_BLANK: blank_r <= wr_data;
                A_CUT:   cut_r   <= wr_data;
                A_GRAD:  grad_r  <= wr_data[NPORT-1:0];
                default: ;
            endcase
        end
    end

    // Shadow copies follow the registers while stopped and at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh   <= '0;
            blank_sh <= '0;
            cut_sh   <= '0;
            grad_sh  <= '0;
            gray_sh  <= 1'b0;
        end else if (!run || wrap) begin
            per_sh   <= per_r;
            blank_sh <= blank_r;
            cut_sh   <= cut_r;
            grad_sh  <= grad_r;
            gray_sh  <= mode_r[M_GRAY];
        end
    end

    // Readback mux; the period address shows the live count.
    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = DW'(mode_r);
            A_PER:   rd_data = cnt;
            A_BLANK: rd_data = blank_r;
            A_CUT:   rd_data = cut_r;
            A_GRAD:  rd_data = DW'(grad_r);
            default: rd_data = '0;
        endcase
    end

    vfd_prescaler #(.DIV0(DIV0), .DIV1(DIV1)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(mode_r[M_SEL]), .tick(tick)
    );

    vfd_slot_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .per(per_sh), .cnt(cnt), .wrap(wrap)
    );

    assign slot_end = wrap;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        vfd_port_gate #(.DW(DW)) u_gate (
            .run(run), .dark(gray_sh && grad_sh[i]), .cnt(cnt),
            .blank(blank_sh), .cut(cut_sh), .en(port_en[i])
        );
    end
endmodule

// File: rtl/vfd_timing_chk.sv
// Checker for the digit timing generator, attached to the top by bind.
// Assumes DIV0, DIV1 >= 2 so that ticks never occur back to back.
module vfd_timing_chk #(
    parameter int NPORT = 8,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             gray_sh,
    input logic [DW-1:0]    cnt,
    input logic [DW-1:0]    per_sh,
    input logic [DW-1:0]    blank_sh,
    input logic [NPORT-1:0] port_en,
    input logic             slot_end
);
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (port_en == '0) && !slot_end);                          // R10
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_sh);                                                  // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> cnt == '0);                                         // R1
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                                 // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> !run || $stable(cnt));                          // R2
    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt < blank_sh) |-> port_en == '0);                      // R4
    AST_BRIGHT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        run && !gray_sh && (cnt >= blank_sh) |-> &port_en);              // R7
endmodule

bind vfd_timing_gen vfd_timing_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .gray_sh(gray_sh),
    .cnt(cnt), .per_sh(per_sh), .blank_sh(blank_sh),
    .port_en(port_en), .slot_end(slot_end)
);

// File: tb/sim_vfd_timing_gen.sv
module sim_vfd_timing_gen;
    localparam int TCLK  = 10;
    localparam int NPORT = 4;
    localparam int DW    = 8;
    localparam int DIV0  = 4;
    localparam int DIV1  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [DW-1:0]    wr_data = '0;
    logic [2:0]       rd_addr = 3'd1;
    logic [DW-1:0]    rd_data;
    logic [NPORT-1:0] port_en;
    logic             slot_end;

    int n_run = 0;
    int n_fail = 0;

    vfd_timing_gen #(.NPORT(NPORT), .DW(DW), .DIV0(DIV0), .DIV1(DIV1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .port_en(port_en), .slot_end(slot_end)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [NPORT-1:0] exp_ports(input int c, input int b,
            input int ct, input bit gray, input logic [NPORT-1:0] grad);
        logic [NPORT-1:0] r;
        for (int i = 0; i < NPORT; i++)
            r[i] = (c >= b) && !(gray && grad[i] && c >= ct);
        return r;
    endfunction

    task automatic wait_slot_end();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!slot_end && g < 5000);
        check(slot_end, "R1 strobe seen", 0, 1);
    endtask

    // Checks one full slot clock by clock, starting after the next strobe.
    task automatic run_slot(input int per, input int b, input int ct, input bit gray,
            input logic [NPORT-1:0] grad, input int div, input string req);
        int cyc = 0;
        int c;
        int bad = 0;
        rd_addr = 3'd1;
        wait_slot_end();
        do begin
            @(negedge clk);
            cyc++;
            c = (cyc - 1) / div;
            if (rd_data != DW'(c) && bad == 0) begin
                bad++;
                check(1'b0, "R8 live count", int'(rd_data), c);
            end
            if (port_en != exp_ports(c, b, ct, gray, grad)) begin
                bad++;
                check(1'b0, req, int'(port_en), int'(exp_ports(c, b, ct, gray, grad)));
            end
        end while (!slot_end && cyc < 5000);
        check(bad == 0, req, bad, 0);
        check(cyc == (per + 1) * div, "R1 slot length", cyc, (per + 1) * div);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(port_en == '0, "R11 ports low", int'(port_en), 0);
        check(!slot_end, "R11 strobe low", int'(slot_end), 0);
        for (int a = 0; a < 5; a++) begin
            rd_addr = 3'(a);
            #1;
            check(rd_data == '0, "R11 reg zero", int'(rd_data), 0);
        end
        rd_addr = 3'd1;
    endtask

    task automatic t_bright();
        wr(3'd1, 9); wr(3'd2, 2); wr(3'd3, 6); wr(3'd4, 4'b0101);
        wr(3'd0, 3'b001);
        run_slot(9, 2, 6, 1'b0, 4'b0101, DIV0, "R5 R7 R2 bright, gradation ignored");
    endtask

    task automatic t_defer();
        rd_addr = 3'd1;
        wait_slot_end();
        repeat (12) @(negedge clk);
        wr(3'd2, 4);
        check(rd_data == 8'd3, "R9 count at write", int'(rd_data), 3);
        check(port_en == 4'b1111, "R9 old blank kept", int'(port_en), 15);
        run_slot(9, 4, 6, 1'b0, 4'b0101, DIV0, "R9 R4 new blank next slot");
    endtask

    task automatic t_dark();
        wr(3'd0, 3'b101);
        run_slot(9, 4, 6, 1'b1, 4'b0101, DIV0, "R6 dark cut-off mixed ports");
        run_slot(9, 4, 6, 1'b1, 4'b0101, DIV0, "R6 dark repeat slot");
    endtask

    task automatic t_readback();
        int exp_v[5] = '{5, 0, 4, 6, 5};
        for (int a = 0; a < 5; a++) begin
            if (a == 1) continue;
            rd_addr = 3'(a);
            #1;
            check(rd_data == DW'(exp_v[a]), "R8 readback", int'(rd_data), exp_v[a]);
        end
        rd_addr = 3'd1;
    endtask

    task automatic t_slow_and_stop();
        wr(3'd0, 3'b000);
        wr(3'd1, 5); wr(3'd2, 0); wr(3'd3, 3); wr(3'd4, 4'b1001);
        repeat (3) begin
            @(negedge clk);
            check(port_en == '0 && !slot_end, "R10 stopped quiet", int'(port_en), 0);
            check(rd_data == '0, "R10 count held", int'(rd_data), 0);
        end
        wr(3'd0, 3'b111);
        check(rd_data == '0, "R10 start from zero", int'(rd_data), 0);
        run_slot(5, 0, 3, 1'b1, 4'b1001, DIV1, "R3 R4 slow tick, zero blank");
        wr(3'd0, 3'b110);
        @(negedge clk);
        check(port_en == '0, "R10 disable forces low", int'(port_en), 0);
        check(rd_data == '0, "R10 count cleared", int'(rd_data), 0);
    endtask

    initial begin
        #(TCLK * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bright();
        t_defer();
        t_dark();
        t_readback();
        t_slow_and_stop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule